// File: doc/BRIEF.md
# Temperature-Regulated Fan PWM Generator

The block drives a fan through a pulse-width modulated output. A wrapping counter advances once per millisecond tick, so one PWM period is 2^CNT_W ticks (256 ms with the default 8-bit counter, at 1 ms resolution). The output is set high as the counter wraps to zero. It is cleared once the counter rises above a threshold value.

The threshold is not written by a host. A divider counts ticks and issues a control strobe every CTRL_DIV ticks, which is 100 ms by default. At each strobe the block compares a digital temperature sample with a setpoint. It then moves the threshold one step up, one step down, or leaves it alone. The threshold is clamped at both ends of its range.

The PWM edges follow the tick with fixed timing. A threshold update changes the duty only from the next comparison on, so a slow control loop can trail the fan output without disturbing it.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, threshold_o is 0, pwm_o is 1, and the PWM counter and control divider are both at 0.
- R2: Only a cycle with tick_i high advances the PWM counter and the divider. In a cycle without a tick, pwm_o and threshold_o keep their values whatever temp_i and setpoint_i do.
- R3: On the tick that wraps the counter from 2^CNT_W-1 to 0, pwm_o goes high in the next cycle, so the PWM period is 2^CNT_W ticks.
- R4: On a tick that brings the counter to a nonzero value greater than threshold_o, pwm_o goes low. It stays low until the counter wraps to 0, even if the threshold rises meanwhile.
- R5: Every CTRL_DIV-th tick after reset is a control strobe. At a strobe with temp_i > setpoint_i (unsigned), threshold_o rises by 1 in the next cycle.
- R6: At a strobe with temp_i < setpoint_i (unsigned), threshold_o falls by 1 in the next cycle.
- R7: At a strobe with temp_i equal to setpoint_i, threshold_o is unchanged. Outside strobes, threshold_o never changes.
- R8: threshold_o saturates: it stays at 2^CNT_W-1 when asked to rise and stays at 0 when asked to fall.
- R9: With threshold_o at 0, pwm_o is high for exactly one tick per period. With threshold_o at 2^CNT_W-1, pwm_o is high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per PWM step (1 ms) |
| temp_i | input | TEMP_W | Temperature sample, unsigned |
| setpoint_i | input | TEMP_W | Target temperature, unsigned |
| pwm_o | output | 1 | Fan PWM output |
| threshold_o | output | CNT_W | Current PWM threshold |

## Verification
The bench builds the block with CNT_W=4 and CTRL_DIV=4. This gives a 16-tick period and a strobe on every fourth tick. Within a few hundred ticks the threshold can be driven into both clamps, held at equality, and walked back down. Both extreme duty cases of R9 can therefore be counted over a full period. A tick-by-tick reference model checks pwm_o, including the sticky-low behaviour when the threshold rises after the output has been cleared.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // direction of the threshold step, before saturation
  function automatic step_e pick_step(input logic gt, input logic lt);
    if (gt)      return STEP_UP;
    else if (lt) return STEP_DOWN;
    else         return STEP_HOLD;
  endfunction

endpackage

// File: rtl/fan_tick_div.sv
module fan_tick_div #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic strobe_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign strobe_o = tick_i;
    end else begin : g_cnt
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      logic          at_last;

      assign at_last  = (div_q == LAST);
      assign strobe_o = tick_i && at_last;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     div_q <= '0;
        else if (tick_i) div_q <= at_last ? '0 : div_q + 1'b1;
      end

      p_div_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(div_q));
      p_div_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q <= LAST);
    end
  endgenerate

  p_strobe_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> tick_i);

endmodule

// File: rtl/fan_thresh_ctrl.sv
module fan_thresh_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TEMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] setpoint_i,
  output logic [CNT_W-1:0]  thr_o
);
  localparam logic [CNT_W-1:0] THR_MAX = '1;

  logic [CNT_W-1:0] thr_q;
  step_e            step;
  logic             gt, lt;

  assign gt   = temp_i > setpoint_i;
  assign lt   = temp_i < setpoint_i;
  assign step = pick_step(gt, lt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
    end else if (strobe_i) begin
      unique case (step)
        STEP_UP:   if (thr_q != THR_MAX) thr_q <= thr_q + 1'b1;
        STEP_DOWN: if (thr_q != '0)      thr_q <= thr_q - 1'b1;
        default:   ;
      endcase
    end
  end

  assign thr_o = thr_q;

  p_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (temp_i > setpoint_i) && (thr_q != THR_MAX) |=> thr_q == $past(thr_q) + 1'b1);
  p_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (temp_i < setpoint_i) && (thr_q != '0) |=> thr_q == $past(thr_q) - 1'b1);
  p_equal_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (temp_i == setpoint_i) |=> $stable(thr_q));
  p_only_on_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(thr_q));
  p_sat_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (thr_q == THR_MAX) && (temp_i > setpoint_i) |=> thr_q == THR_MAX);
  p_sat_bottom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (thr_q == '0) && (temp_i < setpoint_i) |=> thr_q == '0);

endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             pwm_q;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == '0)        pwm_q <= 1'b1;
      else if (cnt_nxt > thr_i) pwm_q <= 1'b0;
    end
  end

  assign pwm_o = pwm_q;

  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q) && $stable(pwm_q));
  p_wrap_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (cnt_q == CNT_MAX) |=> pwm_q);
  p_fall_above_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_q) |-> (cnt_q != '0) && (cnt_q > $past(thr_i)));
  p_rise_at_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> cnt_q == '0);

endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CTRL_DIV = 100,
  parameter int unsigned TEMP_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] setpoint_i,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  threshold_o
);
  logic             ctrl_stb;
  logic [CNT_W-1:0] thr;

  fan_tick_div #(.DIV(CTRL_DIV)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .strobe_o (ctrl_stb)
  );

  fan_thresh_ctrl #(.CNT_W(CNT_W), .TEMP_W(TEMP_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (ctrl_stb),
    .temp_i     (temp_i),
    .setpoint_i (setpoint_i),
    .thr_o      (thr)
  );

  fan_pwm_core #(.CNT_W(CNT_W)) u_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .thr_i  (thr),
    .pwm_o  (pwm_o)
  );

  assign threshold_o = thr;

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pwm_o) && $stable(threshold_o));

endmodule

// File: tb/sim_fan_pwm_ctrl.sv
module sim_fan_pwm_ctrl;
  localparam int CNT_W  = 4;
  localparam int DIV    = 4;
  localparam int TEMP_W = 10;
  localparam int TMAX   = (1 << CNT_W) - 1;
  localparam int NROW   = 6;

  // stimulus rows: temp, setpoint, ticks, expected threshold afterwards
  localparam int ROW_TEMP [NROW] = '{50, 70, 60, 70, 50, 50};
  localparam int ROW_SET  [NROW] = '{60, 60, 60, 60, 60, 60};
  localparam int ROW_TICK [NROW] = '{ 8, 20, 12, 60, 16, 48};
  localparam int ROW_THR  [NROW] = '{ 0,  5,  5, 15, 11,  0};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [TEMP_W-1:0] temp = '0;
  logic [TEMP_W-1:0] setp = '0;
  logic              pwm;
  logic [CNT_W-1:0]  thr;

  int checks = 0;
  int errors = 0;
  int m_cnt, m_div, m_thr, m_pwm;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fan_pwm_ctrl #(.CNT_W(CNT_W), .CTRL_DIV(DIV), .TEMP_W(TEMP_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .temp_i(temp),
    .setpoint_i(setp), .pwm_o(pwm), .threshold_o(thr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_div = 0; m_thr = 0; m_pwm = 1;
  endtask

  // one tick, then update the reference model and compare
  task automatic do_tick(input bit chk);
    int nxt;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    nxt = (m_cnt + 1) % (TMAX + 1);
    if (nxt == 0)          m_pwm = 1;
    else if (nxt > m_thr)  m_pwm = 0;
    m_cnt = nxt;
    if (m_div == DIV - 1) begin
      m_div = 0;
      if (temp > setp && m_thr < TMAX) m_thr++;
      else if (temp < setp && m_thr > 0) m_thr--;
    end else begin
      m_div++;
    end
    if (chk) begin
      check("R4 pwm per tick", int'(pwm), m_pwm);
      check("R5 threshold per tick", int'(thr), m_thr);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_reset();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int highs;
    do_reset();
    check("R1 reset threshold", int'(thr), 0);
    check("R1 reset pwm", int'(pwm), 1);

    // table walk
    for (int r = 0; r < NROW; r++) begin
      temp = TEMP_W'(ROW_TEMP[r]);
      setp = TEMP_W'(ROW_SET[r]);
      for (int t = 0; t < ROW_TICK[r]; t++) do_tick(1'b1);
      check("R8 R6 R7 table threshold", int'(thr), ROW_THR[r]);
    end

    // R9 threshold zero: one high tick per period (164 ticks done, count=4)
    temp = 10'd60; setp = 10'd60;
    while (m_cnt != 0) do_tick(1'b1);
    highs = 0;
    for (int t = 0; t < TMAX + 1; t++) begin
      if (pwm) highs++;
      do_tick(1'b1);
    end
    check("R9 high ticks at threshold 0", highs, 1);

    // R2: no tick, inputs swing, nothing moves
    begin
      logic p0;
      logic [CNT_W-1:0] t0;
      p0 = pwm; t0 = thr;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        temp = TEMP_W'(i * 25);
        setp = TEMP_W'(500 - i * 7);
      end
      check("R2 pwm held without tick", int'(pwm), int'(p0));
      check("R2 threshold held without tick", int'(thr), int'(t0));
    end

    // R8 top clamp then R9 full duty
    temp = 10'd900; setp = 10'd100;
    for (int t = 0; t < 80; t++) do_tick(1'b1);
    check("R8 clamp at top", int'(thr), TMAX);
    temp = 10'd100;
    while (m_cnt != 0) do_tick(1'b1);
    highs = 0;
    for (int t = 0; t < TMAX + 1; t++) begin
      if (pwm) highs++;
      do_tick(1'b1);
    end
    check("R9 high ticks at threshold max", highs, TMAX + 1);

    // R3 / R4 sticky low: threshold 2, rise after clear stays low to wrap
    do_reset();
    temp = 10'd70; setp = 10'd60;
    for (int t = 0; t < 8; t++) do_tick(1'b1);   // thr=2, count=8
    check("R4 cleared above threshold", int'(pwm), 0);
    for (int t = 0; t < 7; t++) do_tick(1'b1);   // count=15, thr=3
    check("R4 stays low while threshold rises", int'(pwm), 0);
    do_tick(1'b1);                               // wrap
    check("R3 high at wrap", int'(pwm), 1);
    check("R3 counter period", m_cnt, 0);

    // R1 reset mid-run
    do_reset();
    check("R1 threshold after second reset", int'(thr), 0);
    check("R1 pwm after second reset", int'(pwm), 1);
    do_tick(1'b1);
    check("R1 first tick clears at threshold 0", int'(pwm), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule